// File: doc/BRIEF.md
# Dual Audio Sample FIFO with Threshold Requests

This block buffers audio samples between a register-access side and a serializer. It holds two independent 32-entry, 32-bit queues. The transmit queue is filled by register writes and drained by the serializer. The receive queue is filled by the serializer and drained by register reads.

Software sees four words: control, status, thresholds and a data port. The status word reports how full each queue is. It also carries two sticky request bits. The transmit request sets when the transmit queue has drained down to its programmed level. The receive request sets when the receive queue holds more than its programmed level. Each request drives an interrupt output through its own enable bit. Each queue also has a hold bit that keeps it empty. Everything runs on one clock. The reset input is asserted asynchronously and released through a two-stage synchronizer inside the block.

Top module: `afq_sample_fifo`

## Requirements
- R1: While reset is held, every register word reads zero, and all event and interrupt outputs are low.
- R2: Writing the data word (reg_sel = 3) appends to the transmit queue. The serializer sees the oldest entry on ser_tx_data and removes it with ser_tx_pop. The transmit count appears in status bits 29:24 (reg_sel = 1).
- R3: A serializer push stores ser_rx_data in the receive queue. Reading the data word returns the oldest entry and removes it in the same cycle. The receive count appears in status bits 13:8.
- R4: A push into a full queue is discarded, and the count stays at 32. A rejected serializer push raises ser_rx_overrun for one cycle, starting on the clock edge that takes the push.
- R5: A pop from an empty queue is discarded. A register read of the empty receive queue returns zero. A rejected serializer pop raises ser_tx_underrun for one cycle, starting on the clock edge that takes the pop.
- R6: Status bit 16 sets one cycle after the transmit count is at or below the transmit threshold. The transmit threshold is in bits 12:8 of the threshold word (reg_sel = 2).
- R7: Status bit 0 sets one cycle after the receive count exceeds the receive threshold in bits 4:0. With a threshold of 0, this happens as soon as one sample is queued.
- R8: Writing 0 to status bit 16 or bit 0 clears that bit, and writing 1 leaves it unchanged. A cleared bit sets again one cycle later if its condition still holds.
- R9: tx_req_irq equals status bit 16 ANDed with control bit 3. rx_req_irq equals status bit 0 ANDed with control bit 2. The control word is reg_sel = 0.
- R10: While control bit 1 (transmit) or bit 0 (receive) is set, that queue is emptied and kept empty. Pushes and pops to it are ignored and produce no overrun or underrun event.
- R11: Each queue holds exactly 32 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Word select: 0 control, 1 status, 2 thresholds, 3 data |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_rd | input | 1 | Read strobe (pops the receive queue when reg_sel = 3) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| ser_tx_pop | input | 1 | Serializer takes the transmit head |
| ser_tx_data | output | 32 | Transmit queue head |
| ser_tx_underrun | output | 1 | Pulse: a pop found the transmit queue empty |
| ser_rx_push | input | 1 | Serializer delivers a received sample |
| ser_rx_data | input | 32 | Received sample |
| ser_rx_overrun | output | 1 | Pulse: a push found the receive queue full |
| tx_req_irq | output | 1 | Enabled transmit request |
| rx_req_irq | output | 1 | Enabled receive request |

## Verification
Each queue is exercised in several ways:
- short bursts with distinct values, which show ordering errors;
- a full fill of 33 entries followed by a full drain, which exposes off-by-one errors in the depth and the wrap;
- pops and reads on an empty queue, which separate a discarded operation from a corrupted pointer.

The thresholds are walked one entry at a time across their boundary (transmit level 15, receive levels 0 and 2). This distinguishes "at or below" from "below", and "above" from "at or above". Clearing a request while its condition holds and while it does not separates a real write-zero clear from a re-arm. Enabling the hold bit on full and on empty queues checks the flush, and shows that events stay quiet during the hold.

// File: rtl/afq_pkg.sv
package afq_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_THR  = 2'd2,
    SEL_DATA = 2'd3
  } afq_sel_e;

  // control word
  localparam int unsigned TX_IE_BIT   = 3;
  localparam int unsigned RX_IE_BIT   = 2;
  localparam int unsigned TX_HOLD_BIT = 1;
  localparam int unsigned RX_HOLD_BIT = 0;
  // status word
  localparam int unsigned TX_CNT_LSB  = 24;
  localparam int unsigned TX_FLG_BIT  = 16;
  localparam int unsigned RX_CNT_LSB  = 8;
  localparam int unsigned RX_FLG_BIT  = 0;
  // threshold word
  localparam int unsigned TX_THR_LSB  = 8;
  localparam int unsigned RX_THR_LSB  = 0;
endpackage

// File: rtl/afq_fifo.sv
module afq_fifo #(
  parameter int unsigned DW = 32,
  parameter int unsigned DEPTH = 32,
  parameter bit REJECT_ON_PUSH = 1'b0,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          reject
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rej_q, rej_d;
  logic          full, empty, push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  generate
    if (REJECT_ON_PUSH) begin : g_rej_push
      assign rej_d = push & full & ~flush;
    end else begin : g_rej_pop
      assign rej_d = pop & empty & ~flush;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      rej_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      rej_q <= rej_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wp_q] <= push_data;
  end

  assign head   = mem_q[rp_q];
  assign count  = cnt_q;
  assign reject = rej_q;

  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !full && !flush) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r4_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (cnt_q == CW'(DEPTH)));
  a_r5_empty_pop_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> (cnt_q == '0));
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= CW'(DEPTH)));
endmodule

// File: rtl/afq_flag.sv
module afq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_cond,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = clr ? 1'b0 : (flag_q | set_cond);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  a_r8_zero_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag_q);
  // also covers R7 for the receive instance
  a_r6_cond_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cond && !clr) |=> flag_q);
endmodule

// File: rtl/afq_sample_fifo.sv
module afq_sample_fifo
  import afq_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned TW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ser_tx_pop,
  output logic [DW-1:0] ser_tx_data,
  output logic          ser_tx_underrun,
  input  logic          ser_rx_push,
  input  logic [DW-1:0] ser_rx_data,
  output logic          ser_rx_overrun,
  output logic          tx_req_irq,
  output logic          rx_req_irq
);
  // reset: asynchronous assertion, synchronous release
  logic rs1_q, rs2_q, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_n_i = rs2_q;

  afq_sel_e sel;
  assign sel = afq_sel_e'(reg_sel);

  logic          tx_ie_q, tx_ie_d, rx_ie_q, rx_ie_d;
  logic          tx_hold_q, tx_hold_d, rx_hold_q, rx_hold_d;
  logic [TW-1:0] tx_thr_q, tx_thr_d, rx_thr_q, rx_thr_d;

  always_comb begin
    tx_ie_d   = tx_ie_q;
    rx_ie_d   = rx_ie_q;
    tx_hold_d = tx_hold_q;
    rx_hold_d = rx_hold_q;
    tx_thr_d  = tx_thr_q;
    rx_thr_d  = rx_thr_q;
    if (reg_wr && sel == SEL_CTRL) begin
      tx_ie_d   = reg_wdata[TX_IE_BIT];
      rx_ie_d   = reg_wdata[RX_IE_BIT];
      tx_hold_d = reg_wdata[TX_HOLD_BIT];
      rx_hold_d = reg_wdata[RX_HOLD_BIT];
    end
    if (reg_wr && sel == SEL_THR) begin
      tx_thr_d = reg_wdata[TX_THR_LSB +: TW];
      rx_thr_d = reg_wdata[RX_THR_LSB +: TW];
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      tx_ie_q   <= 1'b0;
      rx_ie_q   <= 1'b0;
      tx_hold_q <= 1'b0;
      rx_hold_q <= 1'b0;
      tx_thr_q  <= '0;
      rx_thr_q  <= '0;
    end else begin
      tx_ie_q   <= tx_ie_d;
      rx_ie_q   <= rx_ie_d;
      tx_hold_q <= tx_hold_d;
      rx_hold_q <= rx_hold_d;
      tx_thr_q  <= tx_thr_d;
      rx_thr_q  <= rx_thr_d;
    end
  end

  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [DW-1:0] rx_head;
  logic          data_wr, data_rd;

  assign data_wr = reg_wr && (sel == SEL_DATA);
  assign data_rd = reg_rd && (sel == SEL_DATA);

  afq_fifo #(.DW(DW), .DEPTH(DEPTH), .REJECT_ON_PUSH(1'b0)) u_tx (
    .clk(clk), .rst_n(rst_n_i), .flush(tx_hold_q),
    .push(data_wr), .push_data(reg_wdata), .pop(ser_tx_pop),
    .head(ser_tx_data), .count(tx_cnt), .reject(ser_tx_underrun)
  );

  afq_fifo #(.DW(DW), .DEPTH(DEPTH), .REJECT_ON_PUSH(1'b1)) u_rx (
    .clk(clk), .rst_n(rst_n_i), .flush(rx_hold_q),
    .push(ser_rx_push), .push_data(ser_rx_data), .pop(data_rd),
    .head(rx_head), .count(rx_cnt), .reject(ser_rx_overrun)
  );

  logic tx_cond, rx_cond, tx_clr, rx_clr, tx_flag, rx_flag;
  assign tx_cond = (tx_cnt <= CW'(tx_thr_q));
  assign rx_cond = (rx_cnt > CW'(rx_thr_q));
  assign tx_clr  = reg_wr && (sel == SEL_STAT) && !reg_wdata[TX_FLG_BIT];
  assign rx_clr  = reg_wr && (sel == SEL_STAT) && !reg_wdata[RX_FLG_BIT];

  afq_flag u_tx_flag (.clk(clk), .rst_n(rst_n_i), .set_cond(tx_cond), .clr(tx_clr), .flag(tx_flag));
  afq_flag u_rx_flag (.clk(clk), .rst_n(rst_n_i), .set_cond(rx_cond), .clr(rx_clr), .flag(rx_flag));

  assign tx_req_irq = tx_flag & tx_ie_q;
  assign rx_req_irq = rx_flag & rx_ie_q;

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_CTRL: begin
        reg_rdata[TX_IE_BIT]   = tx_ie_q;
        reg_rdata[RX_IE_BIT]   = rx_ie_q;
        reg_rdata[TX_HOLD_BIT] = tx_hold_q;
        reg_rdata[RX_HOLD_BIT] = rx_hold_q;
      end
      SEL_STAT: begin
        reg_rdata[TX_CNT_LSB +: CW] = tx_cnt;
        reg_rdata[TX_FLG_BIT]       = tx_flag;
        reg_rdata[RX_CNT_LSB +: CW] = rx_cnt;
        reg_rdata[RX_FLG_BIT]       = rx_flag;
      end
      SEL_THR: begin
        reg_rdata[TX_THR_LSB +: TW] = tx_thr_q;
        reg_rdata[RX_THR_LSB +: TW] = rx_thr_q;
      end
      SEL_DATA: reg_rdata = (rx_cnt == '0) ? '0 : rx_head;
      default:  reg_rdata = '0;
    endcase
  end

  a_r10_tx_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n_i)
    tx_hold_q |=> !ser_tx_underrun);
  a_r10_rx_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n_i)
    rx_hold_q |=> !ser_rx_overrun);
endmodule

// File: tb/sim_afq_sample_fifo.sv
`timescale 1ns/1ps
module sim_afq_sample_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ser_tx_pop = 1'b0;
  logic [31:0] ser_tx_data;
  logic        ser_tx_underrun;
  logic        ser_rx_push = 1'b0;
  logic [31:0] ser_rx_data = '0;
  logic        ser_rx_overrun;
  logic        tx_req_irq, rx_req_irq;

  always #2 clk = ~clk;

  afq_sample_fifo u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_tx_pop(ser_tx_pop),
    .ser_tx_data(ser_tx_data), .ser_tx_underrun(ser_tx_underrun),
    .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
    .ser_rx_overrun(ser_rx_overrun), .tx_req_irq(tx_req_irq), .rx_req_irq(rx_req_irq)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] tq[$];
  logic [31:0] rq[$];
  bit txf, rxf, ten, ren, th, rh, tun, rov, ms1, ms2;
  int tthr, rthr;

  function automatic logic [31:0] model_word(input logic [1:0] s);
    logic [31:0] e;
    e = '0;
    case (s)
      2'd0: e[3:0] = {ten, ren, th, rh};
      2'd1: begin
        e[29:24] = 6'(tq.size());
        e[16]    = txf;
        e[13:8]  = 6'(rq.size());
        e[0]     = rxf;
      end
      2'd2: begin
        e[12:8] = 5'(tthr);
        e[4:0]  = 5'(rthr);
      end
      default: e = (rq.size() > 0) ? rq[0] : 32'd0;
    endcase
    return e;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tq.delete(); rq.delete();
      txf = 0; rxf = 0; ten = 0; ren = 0; th = 0; rh = 0;
      tun = 0; rov = 0; tthr = 0; rthr = 0; ms1 = 0; ms2 = 0;
    end else begin
      if (ms2) begin
        int tsz, rsz;
        bit ct, cr, wst;
        tsz = tq.size();
        rsz = rq.size();
        ct  = (tsz <= tthr);
        cr  = (rsz > rthr);
        wst = reg_wr && reg_sel == 2'd1;
        txf = (wst && !reg_wdata[16]) ? 1'b0 : (txf | ct);
        rxf = (wst && !reg_wdata[0])  ? 1'b0 : (rxf | cr);
        tun = 0;
        rov = 0;
        if (th) tq.delete();
        else begin
          if (ser_tx_pop) begin
            if (tsz > 0) void'(tq.pop_front());
            else tun = 1;
          end
          if (reg_wr && reg_sel == 2'd3 && tsz < 32) tq.push_back(reg_wdata);
        end
        if (rh) rq.delete();
        else begin
          if (reg_rd && reg_sel == 2'd3 && rsz > 0) void'(rq.pop_front());
          if (ser_rx_push) begin
            if (rsz < 32) rq.push_back(ser_rx_data);
            else rov = 1;
          end
        end
        if (reg_wr && reg_sel == 2'd0) {ten, ren, th, rh} = reg_wdata[3:0];
        if (reg_wr && reg_sel == 2'd2) begin
          tthr = int'(reg_wdata[12:8]);
          rthr = int'(reg_wdata[4:0]);
        end
      end
      ms2 = ms1;
      ms1 = 1;
    end
  end

  // per-cycle comparison, 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n && ms2) begin
      chk(tx_req_irq == (txf & ten), "R9 tx irq", {31'd0, tx_req_irq}, {31'd0, txf & ten});
      chk(rx_req_irq == (rxf & ren), "R9 rx irq", {31'd0, rx_req_irq}, {31'd0, rxf & ren});
      chk(ser_tx_underrun == tun, "R5 underrun", {31'd0, ser_tx_underrun}, {31'd0, tun});
      chk(ser_rx_overrun == rov, "R4 overrun", {31'd0, ser_rx_overrun}, {31'd0, rov});
      if (tq.size() > 0) chk(ser_tx_data == tq[0], "R2 tx head", ser_tx_data, tq[0]);
      case (reg_sel)
        2'd0: chk(reg_rdata == model_word(reg_sel), "R10 control word", reg_rdata, model_word(reg_sel));
        2'd1: chk(reg_rdata == model_word(reg_sel), "R6/R7 status word", reg_rdata, model_word(reg_sel));
        2'd2: chk(reg_rdata == model_word(reg_sel), "R6 threshold word", reg_rdata, model_word(reg_sel));
        default: chk(reg_rdata == model_word(reg_sel), "R3 data word", reg_rdata, model_word(reg_sel));
      endcase
    end
  end

  // ---------------- stimulus tasks (entered near a falling edge) ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_data(input logic [31:0] exp, input string tag);
    reg_sel = 2'd3; reg_rd = 1'b1;
    #1 chk(reg_rdata == exp, tag, reg_rdata, exp);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] s, output logic [31:0] v);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic txpop();
    ser_tx_pop = 1'b1;
    @(negedge clk);
    ser_tx_pop = 1'b0;
  endtask

  task automatic rxpush(input logic [31:0] d);
    ser_rx_push = 1'b1; ser_rx_data = d;
    @(negedge clk);
    ser_rx_push = 1'b0;
  endtask

  bit done = 0;
  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    // R1: reset state
    repeat (3) @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      peek(2'(s), v);
      chk(v == 32'd0, "R1 word under reset", v, 32'd0);
    end
    chk({tx_req_irq, rx_req_irq, ser_tx_underrun, ser_rx_overrun} == 4'd0, "R1 outputs under reset",
        {28'd0, tx_req_irq, rx_req_irq, ser_tx_underrun, ser_rx_overrun}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R2: short ordered burst
    wr(2'd3, 32'hA1); wr(2'd3, 32'hB2); wr(2'd3, 32'hC3);
    peek(2'd1, v);
    chk(v[29:24] == 6'd3, "R2 tx count", {26'd0, v[29:24]}, 32'd3);
    chk(ser_tx_data == 32'hA1, "R2 head first", ser_tx_data, 32'hA1);
    txpop();
    chk(ser_tx_data == 32'hB2, "R2 head second", ser_tx_data, 32'hB2);
    txpop();
    chk(ser_tx_data == 32'hC3, "R2 head third", ser_tx_data, 32'hC3);
    txpop();

    // R11 / R4: fill with 33, last one dropped
    for (int i = 0; i < 33; i++) wr(2'd3, 32'h100 + i);
    peek(2'd1, v);
    chk(v[29:24] == 6'd32, "R11 tx depth 32", {26'd0, v[29:24]}, 32'd32);
    for (int i = 0; i < 32; i++) begin
      chk(ser_tx_data == 32'h100 + i, "R4 tx drain order", ser_tx_data, 32'h100 + i);
      txpop();
    end
    // R5: pop of empty transmit queue
    txpop();
    chk(ser_tx_underrun == 1'b1, "R5 underrun pulse", {31'd0, ser_tx_underrun}, 32'd1);
    idle(1);
    chk(ser_tx_underrun == 1'b0, "R5 underrun single cycle", {31'd0, ser_tx_underrun}, 32'd0);

    // R3: receive path
    for (int i = 0; i < 5; i++) rxpush(32'h11 + i);
    peek(2'd1, v);
    chk(v[13:8] == 6'd5, "R3 rx count", {26'd0, v[13:8]}, 32'd5);
    for (int i = 0; i < 5; i++) rd_data(32'h11 + i, "R3 rx read order");
    rd_data(32'd0, "R5 empty read returns zero");
    peek(2'd1, v);
    chk(v[13:8] == 6'd0, "R5 rx count stays 0", {26'd0, v[13:8]}, 32'd0);

    // R4: receive overrun
    for (int i = 0; i < 33; i++) rxpush(32'h200 + i);
    chk(ser_rx_overrun == 1'b1, "R4 overrun pulse", {31'd0, ser_rx_overrun}, 32'd1);
    peek(2'd1, v);
    chk(v[13:8] == 6'd32, "R4 rx count capped", {26'd0, v[13:8]}, 32'd32);
    rd_data(32'h200, "R4 rx head kept");

    // R10: receive hold
    wr(2'd0, 32'h1);
    idle(1);
    peek(2'd1, v);
    chk(v[13:8] == 6'd0, "R10 rx flushed", {26'd0, v[13:8]}, 32'd0);
    rxpush(32'hDEAD);
    chk(ser_rx_overrun == 1'b0, "R10 no overrun in hold", {31'd0, ser_rx_overrun}, 32'd0);
    peek(2'd1, v);
    chk(v[13:8] == 6'd0, "R10 rx push ignored", {26'd0, v[13:8]}, 32'd0);
    wr(2'd0, 32'h0);

    // R6: transmit threshold 15
    wr(2'd2, 32'h0000_0F00);
    for (int i = 0; i < 20; i++) wr(2'd3, 32'h300 + i);
    wr(2'd1, 32'h0);
    peek(2'd1, v);
    chk(v[16] == 1'b0, "R6 cleared above threshold", {31'd0, v[16]}, 32'd0);
    repeat (4) txpop();
    idle(1);
    peek(2'd1, v);
    chk(v[16] == 1'b0, "R6 count 16 no request", {31'd0, v[16]}, 32'd0);
    txpop();
    peek(2'd1, v);
    chk(v[16] == 1'b0, "R6 one cycle latency", {31'd0, v[16]}, 32'd0);
    idle(1);
    peek(2'd1, v);
    chk(v[16] == 1'b1, "R6 set at count 15", {31'd0, v[16]}, 32'd1);
    // R9
    chk(tx_req_irq == 1'b0, "R9 masked", {31'd0, tx_req_irq}, 32'd0);
    wr(2'd0, 32'h8);
    chk(tx_req_irq == 1'b1, "R9 enabled", {31'd0, tx_req_irq}, 32'd1);

    // R8: clear while condition holds, then re-arm
    wr(2'd1, 32'h0);
    peek(2'd1, v);
    chk(v[16] == 1'b0, "R8 write zero clears", {31'd0, v[16]}, 32'd0);
    idle(1);
    peek(2'd1, v);
    chk(v[16] == 1'b1, "R8 re-arms", {31'd0, v[16]}, 32'd1);
    for (int i = 0; i < 10; i++) wr(2'd3, 32'h400 + i);
    wr(2'd1, 32'h0);
    wr(2'd1, 32'h0001_0001);
    peek(2'd1, v);
    chk(v[16] == 1'b0, "R8 write one no effect", {31'd0, v[16]}, 32'd0);
    chk(tx_req_irq == 1'b0, "R9 follows flag", {31'd0, tx_req_irq}, 32'd0);

    // R10: transmit hold
    wr(2'd0, 32'h2);
    idle(1);
    peek(2'd1, v);
    chk(v[29:24] == 6'd0, "R10 tx flushed", {26'd0, v[29:24]}, 32'd0);
    wr(2'd3, 32'hBEEF);
    peek(2'd1, v);
    chk(v[29:24] == 6'd0, "R10 tx write ignored", {26'd0, v[29:24]}, 32'd0);
    txpop();
    chk(ser_tx_underrun == 1'b0, "R10 no underrun in hold", {31'd0, ser_tx_underrun}, 32'd0);
    wr(2'd0, 32'h0);

    // R7: receive threshold 0 then 2
    wr(2'd1, 32'h0001_0000);
    peek(2'd1, v);
    chk(v[0] == 1'b0, "R7 rx cleared", {31'd0, v[0]}, 32'd0);
    rxpush(32'h77);
    peek(2'd1, v);
    chk(v[0] == 1'b0, "R7 one cycle latency", {31'd0, v[0]}, 32'd0);
    idle(1);
    peek(2'd1, v);
    chk(v[0] == 1'b1, "R7 threshold 0 one sample", {31'd0, v[0]}, 32'd1);
    wr(2'd2, 32'h0000_0F02);
    wr(2'd1, 32'h0001_0000);
    rxpush(32'h78);
    idle(2);
    peek(2'd1, v);
    chk(v[0] == 1'b0, "R7 count equal to threshold", {31'd0, v[0]}, 32'd0);
    rxpush(32'h79);
    idle(1);
    peek(2'd1, v);
    chk(v[0] == 1'b1, "R7 count above threshold", {31'd0, v[0]}, 32'd1);
    wr(2'd0, 32'h4);
    chk(rx_req_irq == 1'b1, "R9 rx enabled", {31'd0, rx_req_irq}, 32'd1);
    idle(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule